// File: doc/BRIEF.md
# Parallel I/O Configuration and Register Block

This block is the processor-facing side of a 24-line parallel I/O controller. A host reaches it through a small asynchronous-style bus: an active-low select, active-low read and write strobes, a 2-bit address and a byte of data. The data side is split into a write-data input, a read-data output and a drive-enable, so a pad ring or bus fabric can build the tristate. Three addresses reach the data registers of ports A, B and C. The fourth address takes configuration commands.

A configuration byte has two meanings, chosen by its top bit. With the top bit set, it is a mode word. The mode word sets the direction of port A, port B and each half of port C, and it sets the mode of group A and group B. Writing a mode word also clears every output latch. With the top bit clear, the byte sets or clears a single port C line and leaves the configuration alone.

Output latches always drive the pin outputs. A per-port output enable tells the pad which lines actually drive. Reads of an input port or input half return the pins as they are at that moment, with no capture. Reads of an output port return the latch. The group-mode fields are exported so that separate handshake logic can use them.

Top module: `pario_ctrl`

## Requirements
- R1: With `cs_n` high, a write strobe changes no latch and no configuration, and `dout_en` stays 0 during a read strobe.
- R2: After reset every output enable is 0 (all ports input), both group modes are 0, and every output latch is 0x00.
- R3: In a mode word (bit 7 = 1), a direction bit of 1 means input. Bit 4 sets the direction of port A, bit 1 port B, bit 3 port C lines 7:4 and bit 0 port C lines 3:0. Each output enable is the inverse of its direction bit.
- R4: In a mode word, bit 2 gives the group B mode (`grp_b_mode`). Bits 6:5 give the group A mode on `grp_a_mode`: 00 gives 0, 01 gives 1, and 10 or 11 gives 2.
- R5: A control byte with bit 7 = 0 loads bit 0 into the port C latch bit chosen by bits 3:1 (000 = line 0 through 111 = line 7). Bits 6:4 have no effect, and 0x0B drives line 5 high.
- R6: A set/reset byte leaves every direction and both group modes unchanged.
- R7: A mode word clears the latches of all three ports to 0x00.
- R8: Address 00 writes the port A latch, 01 port B and 10 port C. An output latch holds its value until written again, and a read of an output port returns the latch.
- R9: A read of an input port returns the current pin value combinationally, so a pin change shows on the next read with no capture.
- R10: The port C halves are independent. A read of address 10 takes each half from the pins if that half is input and from the latch if it is output. Mode word 0x8A makes port B and port C lines 7:4 inputs, and port A and port C lines 3:0 outputs.
- R11: A read of address 11 returns 0x00. `dout_en` is 1 only while `cs_n` and `rd_n` are both low, and `dout` is 0x00 otherwise.
- R12: A write takes effect on the first rising clock edge at which `wr_n` is sampled low. A strobe held low for several cycles acts only once, even if the data changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, sampled on clk |
| addr | input | 2 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Read data drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-line drive enable |
| grp_a_mode | output | 2 | Group A mode: 0, 1 or 2 |
| grp_b_mode | output | 1 | Group B mode: 0 or 1 |

## Verification
The assertions take for granted that `wr_n` is high across reset, that `cs_n`, `addr` and `din` are settled at the edge where a low write strobe is first sampled, and that read and write strobes are never low together. The stimulus changes inputs only on falling clock edges. It opens each access with select, address and data already valid, holds a write strobe for at least one rising edge, and returns all strobes high before the next access. The one deliberate exception is a long write strobe whose data changes while it is held. That case is within the assumptions, because only the first sampled edge counts.

// File: rtl/pario_pkg.sv
`timescale 1ns/1ps
package pario_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      SEL_A    = 2'd0,
      SEL_B    = 2'd1,
      SEL_C    = 2'd2,
      SEL_CTRL = 2'd3
   } pario_sel_e;

   typedef enum logic [1:0] {
      GA_M0 = 2'd0,
      GA_M1 = 2'd1,
      GA_M2 = 2'd2
   } grpa_mode_e;

   typedef struct packed {
      grpa_mode_e a_mode;
      logic       b_mode;
      logic       a_in;
      logic       b_in;
      logic       cu_in;
      logic       cl_in;
   } pario_cfg_t;

   localparam pario_cfg_t CFG_RESET = '{a_mode: GA_M0, b_mode: 1'b0,
                                        a_in: 1'b1, b_in: 1'b1,
                                        cu_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pario_bus_sync.sv
`timescale 1ns/1ps
module pario_bus_sync #(
   parameter int unsigned ADDR_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     wr_n,
   input  logic [ADDR_W-1:0]        addr,
   output logic [(1<<ADDR_W)-1:0]   wr_hit
);
   logic wr_n_q;
   logic fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_n_q <= 1'b1;
      else        wr_n_q <= wr_n;
   end

   assign fire = ~cs_n & ~wr_n & wr_n_q;

   always_comb begin
      wr_hit = '0;
      if (fire) wr_hit[addr] = 1'b1;
   end

   // R12
   wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_hit) |=> (wr_hit == '0));

   // R8
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit));
endmodule

// File: rtl/pario_cfg_reg.sv
`timescale 1ns/1ps
module pario_cfg_reg
   import pario_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   output pario_cfg_t        cfg,
   output logic              mode_wr,
   output logic              bsr_wr,
   output logic [2:0]        bsr_sel,
   output logic              bsr_val
);
   grpa_mode_e a_mode_nxt;

   assign mode_wr = wr_ctrl &  wdata[7];
   assign bsr_wr  = wr_ctrl & ~wdata[7];
   assign bsr_sel = wdata[3:1];
   assign bsr_val = wdata[0];

   always_comb begin
      if (wdata[6])      a_mode_nxt = GA_M2;
      else if (wdata[5]) a_mode_nxt = GA_M1;
      else               a_mode_nxt = GA_M0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RESET;
      end else if (mode_wr) begin
         cfg <= '{a_mode: a_mode_nxt, b_mode: wdata[2], a_in: wdata[4],
                  b_in: wdata[1], cu_in: wdata[3], cl_in: wdata[0]};
      end
   end

   // R6
   bsr_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bsr_wr |=> (cfg == $past(cfg)));

   // R3
   mode_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (cfg.a_in == $past(wdata[4]) && cfg.cl_in == $past(wdata[0])));
endmodule

// File: rtl/pario_out_latch.sv
`timescale 1ns/1ps
module pario_out_latch #(
   parameter int unsigned W           = 8,
   parameter bit          CLR_ON_MODE = 1'b1,
   parameter int unsigned SEL_W       = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [W-1:0]     wdata,
   input  logic             bit_wr,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             bit_val,
   output logic [W-1:0]     q
);
   logic clr_eff;

   if (CLR_ON_MODE) begin : g_clr
      assign clr_eff = clr;
   end else begin : g_noclr
      assign clr_eff = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clr_eff) q <= '0;
      else if (wr)      q <= wdata;
      else if (bit_wr)  q[bit_sel] <= bit_val;
   end

   // R5
   bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !wr && !clr_eff) |=> (q[$past(bit_sel)] == $past(bit_val)));

   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !bit_wr && !clr_eff) |=> $stable(q));
endmodule

// File: rtl/pario_ctrl.sv
`timescale 1ns/1ps
module pario_ctrl
   import pario_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter bit          CLR_ON_MODE = 1'b1,
   parameter logic [7:0]  CTRL_RD_VAL = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PORT_W-1:0] din,
   output logic [PORT_W-1:0] dout,
   output logic              dout_en,
   input  logic [PORT_W-1:0] pa_i,
   output logic [PORT_W-1:0] pa_o,
   output logic              pa_oe,
   input  logic [PORT_W-1:0] pb_i,
   output logic [PORT_W-1:0] pb_o,
   output logic              pb_oe,
   input  logic [PORT_W-1:0] pc_i,
   output logic [PORT_W-1:0] pc_o,
   output logic [PORT_W-1:0] pc_oe,
   output logic [1:0]        grp_a_mode,
   output logic              grp_b_mode
);
   localparam int unsigned HALF   = PORT_W / 2;
   localparam int unsigned NSEL   = 1 << ADDR_W;
   localparam int unsigned NPORT  = 3;
   localparam int unsigned SEL_W  = $clog2(PORT_W);

   if (PORT_W != BYTE_W) begin : g_bad_width
      $error("pario_ctrl: PORT_W must equal the bus byte width");
   end
   if (ADDR_W != 2) begin : g_bad_addr
      $error("pario_ctrl: ADDR_W must be 2");
   end

   logic [NSEL-1:0]   wr_hit;
   pario_cfg_t        cfg;
   logic              mode_wr, bsr_wr, bsr_val;
   logic [SEL_W-1:0]  bsr_sel;
   logic [PORT_W-1:0] lat_q [NPORT];
   logic [PORT_W-1:0] rd_val;

   pario_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
      .addr(addr), .wr_hit(wr_hit));

   pario_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_hit[SEL_CTRL]), .wdata(din),
      .cfg(cfg), .mode_wr(mode_wr), .bsr_wr(bsr_wr),
      .bsr_sel(bsr_sel), .bsr_val(bsr_val));

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      pario_out_latch #(.W(PORT_W), .CLR_ON_MODE(CLR_ON_MODE)) u_lat (
         .clk(clk), .rst_n(rst_n), .clr(mode_wr), .wr(wr_hit[p]),
         .wdata(din),
         .bit_wr((p == int'(SEL_C)) ? bsr_wr : 1'b0),
         .bit_sel(bsr_sel), .bit_val(bsr_val), .q(lat_q[p]));
   end

   always_comb begin
      case (pario_sel_e'(addr))
         SEL_A:   rd_val = cfg.a_in ? pa_i : lat_q[0];
         SEL_B:   rd_val = cfg.b_in ? pb_i : lat_q[1];
         SEL_C:   rd_val = {cfg.cu_in ? pc_i[PORT_W-1:HALF] : lat_q[2][PORT_W-1:HALF],
                            cfg.cl_in ? pc_i[HALF-1:0]      : lat_q[2][HALF-1:0]};
         default: rd_val = CTRL_RD_VAL;
      endcase
   end

   assign dout_en    = ~cs_n & ~rd_n;
   assign dout       = dout_en ? rd_val : '0;
   assign pa_o       = lat_q[0];
   assign pb_o       = lat_q[1];
   assign pc_o       = lat_q[2];
   assign pa_oe      = ~cfg.a_in;
   assign pb_oe      = ~cfg.b_in;
   assign pc_oe      = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
   assign grp_a_mode = cfg.a_mode;
   assign grp_b_mode = cfg.b_mode;

   // R7
   mode_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && CLR_ON_MODE) |=> (pa_o == '0 && pb_o == '0 && pc_o == '0));

   // R11
   ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == ADDR_W'(SEL_CTRL)) |-> (dout == CTRL_RD_VAL));

   // R1
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe)));
endmodule

// File: tb/pario_ctrl_bench.sv
`timescale 1ns/1ps
module pario_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic       dout_en;
   logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
   logic [7:0] pa_o, pb_o, pc_o, pc_oe;
   logic       pa_oe, pb_oe, grp_b_mode;
   logic [1:0] grp_a_mode;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   pario_ctrl u_pario_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
      .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
      .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe),
      .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1;
   endtask

   // driver: pushes the expected read value for the monitor
   task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   // monitor: pops and compares whenever the bus is driven
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (dout_en) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R11: unexpected drive %h expected none", dout);
            end else begin
               chk(tag_q.pop_front(), dout, exp_q.pop_front());
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 pa_oe", {7'd0, pa_oe}, 8'h00);
      chk("R2 pb_oe", {7'd0, pb_oe}, 8'h00);
      chk("R2 pc_oe", pc_oe, 8'h00);
      chk("R2 modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h00);
      chk("R2 latches", pa_o | pb_o | pc_o, 8'h00);

      // R9 inputs read straight from the pins
      pa_i = 8'h5A;
      bus_rd(2'b00, 8'h5A, "R9 read A");
      pa_i = 8'hC3;
      bus_rd(2'b00, 8'hC3, "R9 read A after pin change");

      // R3 all outputs
      bus_wr(2'b11, 8'h80);
      chk("R3 pa_oe", {7'd0, pa_oe}, 8'h01);
      chk("R3 pb_oe", {7'd0, pb_oe}, 8'h01);
      chk("R3 pc_oe", pc_oe, 8'hFF);

      // R8 latches per address
      bus_wr(2'b00, 8'h12);
      bus_wr(2'b01, 8'h34);
      bus_wr(2'b10, 8'h56);
      chk("R8 pa_o", pa_o, 8'h12);
      chk("R8 pb_o", pb_o, 8'h34);
      chk("R8 pc_o", pc_o, 8'h56);
      pa_i = 8'hFF;
      bus_rd(2'b00, 8'h12, "R8 read output A");
      bus_rd(2'b01, 8'h34, "R8 read output B");

      // R1 deselected write and read
      @(negedge clk);
      addr = 2'b00; din = 8'hFF; wr_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      wr_n = 1'b1;
      chk("R1 deselected write", pa_o, 8'h12);
      rd_n = 1'b0;
      #1;
      chk("R1 deselected read en", {7'd0, dout_en}, 8'h00);
      chk("R11 idle dout", dout, 8'h00);
      @(negedge clk);
      rd_n = 1'b1;

      // R11 control read
      bus_rd(2'b11, 8'h00, "R11 read ctrl");

      // R5 bit set/reset
      bus_wr(2'b11, 8'h0B);
      chk("R5 set line5", pc_o, 8'h76);
      bus_wr(2'b11, 8'h72);
      chk("R5 clear line1 bits6:4 ignored", pc_o, 8'h74);
      // R6 config untouched
      chk("R6 pc_oe", pc_oe, 8'hFF);
      chk("R6 pa/pb oe", {6'd0, pa_oe, pb_oe}, 8'h03);
      chk("R6 modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h00);

      // R10 / R7 mixed halves
      bus_wr(2'b11, 8'h8A);
      chk("R10 pc_oe", pc_oe, 8'h0F);
      chk("R10 pa/pb oe", {6'd0, pa_oe, pb_oe}, 8'h02);
      chk("R7 cleared", pa_o | pb_o | pc_o, 8'h00);
      pc_i = 8'hA5;
      bus_rd(2'b10, 8'hA0, "R10 read C halves");
      bus_wr(2'b11, 8'h01);
      bus_rd(2'b10, 8'hA1, "R10 read C after bit set");
      pb_i = 8'h3C;
      bus_rd(2'b01, 8'h3C, "R9 read input B");

      // R4 group modes
      bus_wr(2'b11, 8'hC4);
      chk("R4 a=2 b=1", {5'd0, grp_a_mode, grp_b_mode}, 8'h05);
      bus_wr(2'b11, 8'hA0);
      chk("R4 a=1 b=0", {5'd0, grp_a_mode, grp_b_mode}, 8'h02);
      bus_wr(2'b11, 8'hE0);
      chk("R4 a=2 from 11", {5'd0, grp_a_mode, grp_b_mode}, 8'h04);

      // R12 long strobe acts once
      @(negedge clk);
      cs_n = 1'b0; addr = 2'b01; din = 8'h11; wr_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R12 first edge", pb_o, 8'h11);
      din = 8'h22;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R12 held strobe once", pb_o, 8'h11);
      wr_n = 1'b1; cs_n = 1'b1;

      repeat (3) @(negedge clk);
      chk("R11 queue drained", 8'(exp_q.size()), 8'h00);
      finish_run();
   end
endmodule